// File: doc/BRIEF.md
# Two-Way Cache Store Pipeline with Load Forwarding

This block is the store path of a small two-way set-associative data cache. Its tag and data arrays live inside the block. A store takes two steps. In the first cycle it compares tags to find the way that holds its line. In the following cycle it writes its enabled bytes into that way only. The two steps are decoupled. While one store is being written, the next store can already be checking its tags, so a stream of hitting stores is accepted at one per cycle.

Loads read tags and data together and return their result one cycle after the request. A store that has passed its tag check but is still waiting in the write stage is visible to loads: a load to the same word gets the pending bytes merged over the array contents.

A store that misses raises a stall. While the stall is high the pipeline takes no new stores. The line is then supplied on a fill input and installed into a victim way. The waiting store repeats its tag check, which now hits, and completes normally.

Top module: `stpipe_top`

## Requirements
- R1: After reset the stall output is low, no load response is valid and every line is invalid, so any load reports a miss.
- R2: A load presented in cycle t gives ldRespValid high in cycle t+1, with ldRespHit set when its line is resident. On a miss ldRespData is zero. With no load request, ldRespValid is low in the next cycle.
- R3: A store that hits in cycle t changes the word seen by every load presented in cycle t+1 or later. A load presented in the same cycle t sees the value from before that store.
- R4: Byte enable bit i selects data bits 8i+7 down to 8i. Only the enabled bytes of the addressed word change.
- R5: A store that misses in cycle t makes the stall output high from cycle t+1. The stall stays high until a fill has been taken. While stalled, lines already resident keep their contents, and loads to them still hit.
- R6: While the stall output is high, store requests are ignored and never reach the arrays.
- R7: A fill taken while stalled installs the missing line. It goes into way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the way named by a per-set pointer that starts at 0 and flips on every install into that set. Fill word k sits at bits 32k+31 down to 32k. The missing store retries its tag check in the cycle after the fill, then writes its bytes. The stall falls two cycles after the fill cycle, and the evicted line then misses.
- R8: A load presented one cycle after a hitting store, to the same line and word, returns the store's enabled bytes merged over the array bytes.
- R9: Stores that hit on consecutive cycles, including several stores to one word, all take effect in issue order.
- R10: Forwarding requires the full line address and word to match. A load to another line in the same set, or to another word of the same line, reads only the array while a write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| stReqValid | input | 1 | Store request present this cycle |
| stReqAddr | input | ADDR_W | Store byte address (low two bits ignored) |
| stReqData | input | DATA_W | Store data word |
| stReqBe | input | DATA_W/8 | Store byte enables |
| stall | output | 1 | High while a store miss waits for its fill |
| ldReqValid | input | 1 | Load request present this cycle |
| ldReqAddr | input | ADDR_W | Load byte address (low two bits ignored) |
| ldRespValid | output | 1 | Load result valid, one cycle after the request |
| ldRespHit | output | 1 | Load line was resident |
| ldRespData | output | DATA_W | Load word, zero on a miss |
| fillValid | input | 1 | Fill line present (taken only while stalled) |
| fillData | input | DATA_W*WORDS | Fill line, word k at bits DATA_W*k upward |

## Verification
The hardest state to reach is a set that is full when a third line arrives. In that state a store miss stalls the pipe while a store to a resident line of the same set is offered and must be dropped. The fill must then evict the line that the per-set pointer names. The stimulus gets there in three steps. It fills two lines of set 0 through store misses. It then misses on a third line of that set and, during the stall, presents a store to one of the resident lines together with loads of that line. Once the fill is taken, loads show that the older line has left, that the other line survived, and that the retried store landed through forwarding and then through the array.

// File: rtl/stpipe_pkg.sv
package stpipe_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_WAIT  = 2'd1,
    PH_RETRY = 2'd2
  } phase_t;

  typedef struct packed {
    logic fromMiss;
    logic advance;
    logic captureMiss;
    logic install;
  } ctrlStrb_t;
endpackage

// File: rtl/stpipe_ctrl.sv
module stpipe_ctrl
  import stpipe_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stReqValid,
  input  logic      fillValid,
  input  logic      tagHit,
  output ctrlStrb_t strb,
  output logic      stall
);
  phase_t phase, phaseNxt;

  always_comb begin
    strb     = '0;
    phaseNxt = phase;
    unique case (phase)
      PH_RUN: begin
        if (stReqValid) begin
          if (tagHit) begin
            strb.advance = 1'b1;
          end else begin
            strb.captureMiss = 1'b1;
            phaseNxt         = PH_WAIT;
          end
        end
      end
      PH_WAIT: begin
        if (fillValid) begin
          strb.install = 1'b1;
          phaseNxt     = PH_RETRY;
        end
      end
      PH_RETRY: begin
        strb.fromMiss = 1'b1;
        if (tagHit) begin
          strb.advance = 1'b1;
          phaseNxt     = PH_RUN;
        end else begin
          phaseNxt = PH_WAIT;
        end
      end
      default: phaseNxt = PH_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_RUN;
    else       phase <= phaseNxt;
  end

  assign stall = (phase != PH_RUN);
endmodule

// File: rtl/stpipe_datapath.sv
module stpipe_datapath
  import stpipe_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrb_t                strb,
  input  logic [ADDR_W-1:0]        stReqAddr,
  input  logic [DATA_W-1:0]        stReqData,
  input  logic [DATA_W/8-1:0]      stReqBe,
  input  logic                     ldReqValid,
  input  logic [ADDR_W-1:0]        ldReqAddr,
  input  logic [DATA_W*WORDS-1:0]  fillData,
  output logic                     tagHit,
  output logic                     wrValid,
  output logic                     ldRespValid,
  output logic                     ldRespHit,
  output logic [DATA_W-1:0]        ldRespData
);
  localparam int BYTES  = DATA_W / 8;
  localparam int BYTE_W = $clog2(BYTES);
  localparam int WORD_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int SLOT_W = IDX_W + WORD_W;
  localparam int LINE_W = ADDR_W - BYTE_W - WORD_W;
  localparam int TAG_W  = LINE_W - IDX_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  // Arrays
  logic [TAG_W-1:0]  tagArr   [WAYS][SETS];
  logic [SETS-1:0]   validArr [WAYS];
  logic [DATA_W-1:0] dataArr  [WAYS][SETS*WORDS];
  logic [SETS-1:0]   victimPtr;

  // Miss holding register
  logic [ADDR_W-1:0] missAddr;
  logic [DATA_W-1:0] missData;
  logic [BYTES-1:0]  missBe;

  // Write stage
  logic [WAY_W-1:0]  wrWay;
  logic [SLOT_W-1:0] wrSlot;
  logic [LINE_W-1:0] wrLine;
  logic [DATA_W-1:0] wrData;
  logic [BYTES-1:0]  wrBe;

  // Tag-check candidate
  logic [ADDR_W-1:0] candAddr;
  logic [DATA_W-1:0] candData;
  logic [BYTES-1:0]  candBe;
  logic [TAG_W-1:0]  candTag;
  logic [IDX_W-1:0]  candIdx;
  logic [WORD_W-1:0] candWord;
  logic [WAYS-1:0]   candHitVec;
  logic [WAY_W-1:0]  candHitWay;

  assign candAddr = strb.fromMiss ? missAddr : stReqAddr;
  assign candData = strb.fromMiss ? missData : stReqData;
  assign candBe   = strb.fromMiss ? missBe   : stReqBe;
  assign candTag  = candAddr[ADDR_W-1 -: TAG_W];
  assign candIdx  = candAddr[BYTE_W+WORD_W +: IDX_W];
  assign candWord = candAddr[BYTE_W +: WORD_W];

  // Load address fields
  logic [TAG_W-1:0]  ldTag;
  logic [IDX_W-1:0]  ldIdx;
  logic [WORD_W-1:0] ldWord;
  logic [LINE_W-1:0] ldLine;
  logic [WAYS-1:0]   ldHitVec;
  logic [WAY_W-1:0]  ldHitWay;

  assign ldTag  = ldReqAddr[ADDR_W-1 -: TAG_W];
  assign ldIdx  = ldReqAddr[BYTE_W+WORD_W +: IDX_W];
  assign ldWord = ldReqAddr[BYTE_W +: WORD_W];
  assign ldLine = ldReqAddr[ADDR_W-1 -: LINE_W];

  // One comparator per way for each of the two lookups
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign candHitVec[w] = validArr[w][candIdx] && (tagArr[w][candIdx] == candTag);
    assign ldHitVec[w]   = validArr[w][ldIdx]   && (tagArr[w][ldIdx]   == ldTag);
  end

  always_comb begin
    candHitWay = '0;
    ldHitWay   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (candHitVec[w]) candHitWay = WAY_W'(w);
      if (ldHitVec[w])   ldHitWay   = WAY_W'(w);
    end
  end

  assign tagHit = |candHitVec;

  // Victim choice for a fill: lowest invalid way, else the set's pointer
  logic [IDX_W-1:0] missIdx;
  logic [TAG_W-1:0] missTag;
  logic [WAY_W-1:0] fillWay;

  assign missIdx = missAddr[BYTE_W+WORD_W +: IDX_W];
  assign missTag = missAddr[ADDR_W-1 -: TAG_W];

  always_comb begin
    fillWay = WAY_W'(victimPtr[missIdx]);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!validArr[w][missIdx]) fillWay = WAY_W'(w);
    end
  end

  // Miss capture
  always_ff @(posedge clk) begin
    if (strb.captureMiss) begin
      missAddr <= stReqAddr;
      missData <= stReqData;
      missBe   <= stReqBe;
    end
  end

  // Write stage register
  always_ff @(posedge clk) begin
    if (!rstN) wrValid <= 1'b0;
    else       wrValid <= strb.advance;
  end

  always_ff @(posedge clk) begin
    if (strb.advance) begin
      wrWay  <= candHitWay;
      wrSlot <= {candIdx, candWord};
      wrLine <= candAddr[ADDR_W-1 -: LINE_W];
      wrData <= candData;
      wrBe   <= candBe;
    end
  end

  // Data array: byte-masked store write, whole-line fill
  always_ff @(posedge clk) begin
    if (wrValid) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wrBe[b]) dataArr[wrWay][wrSlot][b*8 +: 8] <= wrData[b*8 +: 8];
      end
    end
    if (strb.install) begin
      for (int k = 0; k < WORDS; k++) begin
        dataArr[fillWay][{missIdx, WORD_W'(k)}] <= fillData[k*DATA_W +: DATA_W];
      end
    end
  end

  // Tag, valid and victim pointer
  always_ff @(posedge clk) begin
    if (strb.install) tagArr[fillWay][missIdx] <= missTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WAYS; w++) validArr[w] <= '0;
      victimPtr <= '0;
    end else if (strb.install) begin
      validArr[fillWay][missIdx] <= 1'b1;
      victimPtr[missIdx]         <= ~victimPtr[missIdx];
    end
  end

  // Load read with forwarding from the write stage
  logic [DATA_W-1:0] ldArrWord;
  logic [DATA_W-1:0] ldMerged;
  logic              fwdMatch;

  assign ldArrWord = dataArr[ldHitWay][{ldIdx, ldWord}];
  assign fwdMatch  = wrValid && (wrLine == ldLine) && (wrSlot[WORD_W-1:0] == ldWord);

  always_comb begin
    ldMerged = ldArrWord;
    for (int b = 0; b < BYTES; b++) begin
      if (fwdMatch && wrBe[b]) ldMerged[b*8 +: 8] = wrData[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldRespValid <= 1'b0;
      ldRespHit   <= 1'b0;
      ldRespData  <= '0;
    end else begin
      ldRespValid <= ldReqValid;
      ldRespHit   <= ldReqValid && (|ldHitVec);
      ldRespData  <= (ldReqValid && (|ldHitVec)) ? ldMerged : '0;
    end
  end

  logic unusedLowBits;
  assign unusedLowBits = ^{stReqAddr[BYTE_W-1:0], ldReqAddr[BYTE_W-1:0], missAddr[BYTE_W-1:0]};
endmodule

// File: rtl/stpipe_top.sv
module stpipe_top
  import stpipe_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     stReqValid,
  input  logic [ADDR_W-1:0]        stReqAddr,
  input  logic [DATA_W-1:0]        stReqData,
  input  logic [DATA_W/8-1:0]      stReqBe,
  output logic                     stall,
  input  logic                     ldReqValid,
  input  logic [ADDR_W-1:0]        ldReqAddr,
  output logic                     ldRespValid,
  output logic                     ldRespHit,
  output logic [DATA_W-1:0]        ldRespData,
  input  logic                     fillValid,
  input  logic [DATA_W*WORDS-1:0]  fillData
);
  ctrlStrb_t strb;
  logic      tagHit;
  logic      wrValid;

  stpipe_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .stReqValid (stReqValid),
    .fillValid  (fillValid),
    .tagHit     (tagHit),
    .strb       (strb),
    .stall      (stall)
  );

  stpipe_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WORDS  (WORDS),
    .SETS   (SETS)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .stReqAddr   (stReqAddr),
    .stReqData   (stReqData),
    .stReqBe     (stReqBe),
    .ldReqValid  (ldReqValid),
    .ldReqAddr   (ldReqAddr),
    .fillData    (fillData),
    .tagHit      (tagHit),
    .wrValid     (wrValid),
    .ldRespValid (ldRespValid),
    .ldRespHit   (ldRespHit),
    .ldRespData  (ldRespData)
  );
endmodule

// File: rtl/stpipe_chk.sv
module stpipe_chk
  import stpipe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              stReqValid,
  input logic              stall,
  input logic              fillValid,
  input logic              ldReqValid,
  input logic              ldRespValid,
  input logic              ldRespHit,
  input logic [DATA_W-1:0] ldRespData,
  input ctrlStrb_t         strb,
  input logic              tagHit,
  input logic              wrValid
);
  p_load_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    ldReqValid |=> ldRespValid);

  p_no_load_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ldReqValid |=> !ldRespValid);

  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ldRespValid && !ldRespHit) |-> (ldRespData == '0));

  p_stall_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> $past(stReqValid));

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !fillValid && !$past(fillValid)) |=> stall);

  p_stall_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> $past(fillValid, 2));

  p_retry_hits_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.fromMiss |-> tagHit);

  p_fill_no_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.install |-> !wrValid);

  p_stall_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !strb.fromMiss) |=> !wrValid);
endmodule

bind stpipe_top stpipe_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .stReqValid  (stReqValid),
  .stall       (stall),
  .fillValid   (fillValid),
  .ldReqValid  (ldReqValid),
  .ldRespValid (ldRespValid),
  .ldRespHit   (ldRespHit),
  .ldRespData  (ldRespData),
  .strb        (strb),
  .tagHit      (tagHit),
  .wrValid     (wrValid)
);

// File: tb/stpipe_top_tb.sv
module stpipe_top_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         stReqValid = 1'b0;
  logic [15:0]  stReqAddr = '0;
  logic [31:0]  stReqData = '0;
  logic [3:0]   stReqBe = '0;
  logic         stall;
  logic         ldReqValid = 1'b0;
  logic [15:0]  ldReqAddr = '0;
  logic         ldRespValid;
  logic         ldRespHit;
  logic [31:0]  ldRespData;
  logic         fillValid = 1'b0;
  logic [127:0] fillData = '0;

  always #10 clk = ~clk;

  stpipe_top dut_i (
    .clk(clk), .rstN(rstN),
    .stReqValid(stReqValid), .stReqAddr(stReqAddr), .stReqData(stReqData), .stReqBe(stReqBe),
    .stall(stall),
    .ldReqValid(ldReqValid), .ldReqAddr(ldReqAddr),
    .ldRespValid(ldRespValid), .ldRespHit(ldRespHit), .ldRespData(ldRespData),
    .fillValid(fillValid), .fillData(fillData)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model built from the requirements
  logic [31:0] refMem [int];
  int  resLine [8][2];
  bit  resV    [8][2];
  bit  ptr     [8];
  int  mState = 0;
  logic [15:0] pendA;
  logic [31:0] pendD;
  logic [3:0]  pendB;

  function automatic logic [31:0] memRd(int w);
    if (refMem.exists(w)) return refMem[w];
    return (w * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic bit isRes(int line);
    int idx = line & 7;
    return (resV[idx][0] && resLine[idx][0] == line) || (resV[idx][1] && resLine[idx][1] == line);
  endfunction

  function automatic void applyStore(logic [15:0] a, logic [31:0] d, logic [3:0] be);
    int w = int'(a) >> 2;
    logic [31:0] v = memRd(w);
    for (int b = 0; b < 4; b++) if (be[b]) v[b*8 +: 8] = d[b*8 +: 8];
    refMem[w] = v;
  endfunction

  function automatic void install(int line);
    int idx = line & 7;
    int way;
    if (!resV[idx][0]) way = 0;
    else if (!resV[idx][1]) way = 1;
    else way = int'(ptr[idx]);
    resV[idx][way] = 1;
    resLine[idx][way] = line;
    ptr[idx] = ~ptr[idx];
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // One clock cycle; called at a falling edge, returns at the next one
  task automatic cyc(string tag, bit sv, logic [15:0] sa, logic [31:0] sd, logic [3:0] sb,
                     bit lv, logic [15:0] la, bit fv);
    bit          expHit;
    logic [31:0] expData;
    logic [127:0] fd = '0;
    expHit  = isRes(int'(la) >> 4);
    expData = expHit ? memRd(int'(la) >> 2) : 32'h0;
    if (mState == 1 && fv) begin
      for (int k = 0; k < 4; k++) fd[k*32 +: 32] = memRd((int'(pendA) >> 4) * 4 + k);
    end
    stReqValid = sv; stReqAddr = sa; stReqData = sd; stReqBe = sb;
    ldReqValid = lv; ldReqAddr = la;
    fillValid = fv; fillData = fd;
    case (mState)
      0: if (sv) begin
           if (isRes(int'(sa) >> 4)) applyStore(sa, sd, sb);
           else begin mState = 1; pendA = sa; pendD = sd; pendB = sb; end
         end
      1: if (fv) begin install(int'(pendA) >> 4); mState = 2; end
      default: begin applyStore(pendA, pendD, pendB); mState = 0; end
    endcase
    @(posedge clk);
    @(negedge clk);
    chk("R5", "stall", {31'b0, stall}, {31'b0, mState != 0});
    if (lv) begin
      chk("R2", "ldRespValid", {31'b0, ldRespValid}, 32'h1);
      chk(tag, "ldRespHit", {31'b0, ldRespHit}, {31'b0, expHit});
      chk(tag, "ldRespData", ldRespData, expData);
    end else begin
      chk("R2", "idle ldRespValid", {31'b0, ldRespValid}, 32'h0);
    end
    stReqValid = 0; ldReqValid = 0; fillValid = 0;
  endtask

  task automatic settle();
    for (int g = 0; g < 8 && mState != 0; g++) cyc("R7", 0, '0, '0, '0, 0, '0, mState == 1);
  endtask

  typedef struct packed {
    logic        st;
    logic [15:0] sa;
    logic [31:0] sd;
    logic [3:0]  sb;
    logic        ld;
    logic [15:0] la;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b1, 16'h0100, 32'hAAAA_0001, 4'hF, 1'b0, 16'h0000},
    '{1'b1, 16'h0104, 32'h1122_3344, 4'h3, 1'b1, 16'h0100},
    '{1'b1, 16'h0104, 32'h5566_7788, 4'hC, 1'b1, 16'h0104},
    '{1'b0, 16'h0000, 32'h0,         4'h0, 1'b1, 16'h0104},
    '{1'b1, 16'h0108, 32'h99AA_BBCC, 4'h1, 1'b1, 16'h0108},
    '{1'b0, 16'h0000, 32'h0,         4'h0, 1'b1, 16'h0108},
    '{1'b1, 16'h0180, 32'hCAFE_0180, 4'hF, 1'b0, 16'h0000},
    '{1'b1, 16'h0100, 32'h0BAD_F00D, 4'h6, 1'b1, 16'h0180},
    '{1'b0, 16'h0000, 32'h0,         4'h0, 1'b1, 16'h0100},
    '{1'b1, 16'h0110, 32'h1234_5678, 4'h8, 1'b1, 16'h0104},
    '{1'b1, 16'h011C, 32'hFEDC_BA98, 4'hF, 1'b1, 16'h0110},
    '{1'b0, 16'h0000, 32'h0,         4'h0, 1'b1, 16'h011C}
  };

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "stall in reset", {31'b0, stall}, 32'h0);
    chk("R1", "ldRespValid in reset", {31'b0, ldRespValid}, 32'h0);
    rstN = 1'b1;
    cyc("R1", 0, '0, '0, '0, 1, 16'h0040, 0);
    cyc("R1", 0, '0, '0, '0, 1, 16'h0100, 0);

    // Table: store misses and fills, byte enables (R4), same-cycle and
    // forwarded loads (R3, R8)
    foreach (VEC[i]) begin
      cyc("R3 R4 R8", VEC[i].st, VEC[i].sa, VEC[i].sd, VEC[i].sb, VEC[i].ld, VEC[i].la, 0);
      settle();
    end

    // R9: consecutive stores to one word and its neighbours
    cyc("R9", 1, 16'h0100, 32'h0000_0011, 4'h1, 0, '0, 0);
    cyc("R9", 1, 16'h0100, 32'h0000_2200, 4'h2, 1, 16'h0100, 0);
    cyc("R9", 1, 16'h0100, 32'h3300_0000, 4'h8, 1, 16'h0100, 0);
    cyc("R9", 1, 16'h010C, 32'h4444_4444, 4'hF, 1, 16'h0100, 0);
    cyc("R9", 0, '0, '0, '0, 1, 16'h010C, 0);
    cyc("R9", 0, '0, '0, '0, 1, 16'h0100, 0);

    // R10: pending write must not leak to other line in same set or other word
    cyc("R10", 1, 16'h0100, 32'h7777_7777, 4'hF, 0, '0, 0);
    cyc("R10", 0, '0, '0, '0, 1, 16'h0180, 0);
    cyc("R10", 1, 16'h0100, 32'h8888_8888, 4'hF, 0, '0, 0);
    cyc("R10", 0, '0, '0, '0, 1, 16'h0104, 0);

    // R5/R6/R7: third line into full set 0
    cyc("R5", 1, 16'h0200, 32'hD00D_0200, 4'h5, 0, '0, 0);
    cyc("R5", 0, '0, '0, '0, 1, 16'h0100, 0);
    cyc("R6", 1, 16'h0100, 32'hDEAD_BEEF, 4'hF, 1, 16'h0100, 0);
    cyc("R6", 1, 16'h0180, 32'hDEAD_BEEF, 4'hF, 1, 16'h0100, 0);
    cyc("R6", 0, '0, '0, '0, 1, 16'h0180, 0);
    cyc("R7", 0, '0, '0, '0, 1, 16'h0180, 1);
    cyc("R7", 0, '0, '0, '0, 1, 16'h0100, 0);
    cyc("R7", 0, '0, '0, '0, 1, 16'h0200, 0);
    cyc("R7", 0, '0, '0, '0, 1, 16'h0200, 0);
    cyc("R7", 0, '0, '0, '0, 1, 16'h0204, 0);
    cyc("R7", 0, '0, '0, '0, 1, 16'h0180, 0);
    cyc("R7", 1, 16'h0100, 32'h0101_0101, 4'hF, 0, '0, 0);
    settle();
    cyc("R7", 0, '0, '0, '0, 1, 16'h0100, 0);
    cyc("R7", 0, '0, '0, '0, 1, 16'h0200, 0);
    cyc("R7", 0, '0, '0, '0, 1, 16'h0180, 0);
    summary();
  end
endmodule